// File: doc/BRIEF.md
# Range-Matching Translation Buffer with Pinned Slots

This block is a small fully-associative address translation buffer. Each entry maps one aligned virtual range, which is one base page or the base page times a power of four, onto a physical base, and it carries a protection word. A lookup presents a virtual address and, one cycle later, receives a hit flag, the translated physical address (physical base plus the offset of the address within the range) and the protection word of the matching entry. Checking those permissions is the job of a separate block.

The lowest slots are pinned block entries. Ordinary inserts, purges, purge-all and victim replacement never touch them. Only the forced block commands, which name a slot directly, can write or clear them. Ordinary entries are filled from free slots first, and a rotating victim pointer is used only when no free slot is left. Besides the single-step insert, there is an older two-step insert: an address step reserves a pending entry, and a later protection step completes it.

A command port takes one command per cycle and a lookup port takes one lookup per cycle. A lookup sees the table as it was before any command issued in the same cycle.

Top module: `tlb_range`

## Requirements
- R1: A lookup with `lk_req` high returns its result on the clock edge that samples it: `lk_hit`=1 with `lk_pa` = physical base + (lookup address − range start) and `lk_prot` = the stored protection word when a valid entry covers the address, else `lk_hit`=0.
- R2: An entry with size code c (4 bits) covers 2^(PAGE_BITS+2c) bytes, and its start is the given virtual address aligned down to that size. Code 0 is one page.
- R3: When several valid entries cover a lookup address, the entry with the lowest slot index supplies the result.
- R4: Insert (cmd 1) first removes every valid non-pinned entry whose range overlaps the new range, then writes the new entry as valid.
- R5: An insert takes the lowest-indexed free non-pinned slot. If none is free, it takes the slot at a victim pointer, which starts at PINNED, steps by one on each such use, and wraps from ENTRIES−1 back to PINNED.
- R6: Purge (cmd 4) takes the page-aligned part of `cmd_va` as the start and `cmd_va[3:0]` as a range code c. It removes every non-pinned valid entry that overlaps start .. start + (page << 2c) − 1.
- R7: Address step (cmd 2) reserves a pending, not yet valid, one-page entry with `cmd_pa` as its base. Protection step (cmd 3) makes that entry valid with `cmd_prot` when `cmd_va` lies in its page. Otherwise the step is dropped and the pending entry is cancelled.
- R8: Purge-all (cmd 5) invalidates every non-pinned entry, cancels any pending entry and returns the victim pointer to PINNED. Valid pinned entries stay.
- R9: Block insert (cmd 6) and block purge (cmd 7) act on slot `cmd_slot`. If `cmd_slot` ≥ PINNED, `cmd_err` is 1 on the following cycle and the table is unchanged. A block insert stores `cmd_prot` with bit ID_W+8 (dirty, bit 24 by default) forced to 1 and bit ID_W+9 (reference trap, bit 25 by default) forced to 0.
- R10: Pinned slots (index < PINNED) keep their contents through insert, address step, purge and purge-all.
- R11: After reset every entry is invalid, no entry is pending, and `lk_hit` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_pa | output | PA_W | Translated physical address |
| lk_prot | output | PROT_W | Protection word of the matching entry |
| cmd | input | 3 | Command: 0 none, 1 insert, 2 address step, 3 protection step, 4 purge, 5 purge-all, 6 block insert, 7 block purge |
| cmd_va | input | VA_W | Virtual address; for purge the low 4 bits are the range code |
| cmd_code | input | 4 | Size code for insert and block insert |
| cmd_pa | input | PA_W | Physical base for insert, address step and block insert |
| cmd_prot | input | PROT_W | Protection word for insert, protection step and block insert |
| cmd_slot | input | SLOT_W | Slot for block commands |
| cmd_err | output | 1 | Block command slot out of range, one cycle after command |

## Verification
A wrong valid bit or a wrong range in the table shows up as a wrong hit flag or a wrong physical address on the first lookup that touches that range. A pinned slot that is damaged by an ordinary purge is caught by looking up the pinned range right after the purge. A victim pointer that steps or wraps wrongly stays hidden until the table is full. It becomes visible only after a whole round of replacements, when a lookup finds the wrong translation evicted, so the directed fill pushes the pointer past its wrap point. A pending entry that is not cancelled correctly shows up on the lookup that follows the protection step.

// File: rtl/tlbr_pkg.sv
// Shared types of the range-matching translation buffer.
// Assumes: one command per cycle, encoded as below.
package tlbr_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_INSERT  = 3'd1,
        OP_ASTEP   = 3'd2,
        OP_PSTEP   = 3'd3,
        OP_PURGE   = 3'd4,
        OP_PALL    = 3'd5,
        OP_BINSERT = 3'd6,
        OP_BPURGE  = 3'd7
    } op_e;

    localparam int CODE_W = 4;
endpackage

// File: rtl/tlbr_match.sv
// One entry's comparators: lookup containment and command-range overlap.
// Assumes: start is aligned to (mask+1) and mask is a contiguous low mask.
module tlbr_match #(
    parameter int VA_W = 32
) (
    input  logic            vld,
    input  logic [VA_W-1:0] start,
    input  logic [VA_W-1:0] mask,
    input  logic [VA_W-1:0] lk_va,
    input  logic [VA_W-1:0] q_lo,
    input  logic [VA_W-1:0] q_hi,
    output logic            hit,
    output logic            ovl
);
    // lookup address lies inside this entry's range
    assign hit = vld && ((lk_va & ~mask) == start);
    // command range [q_lo, q_hi] intersects this entry's range
    assign ovl = vld && (start <= q_hi) && (q_lo <= (start | mask));
endmodule

// File: rtl/tlbr_alloc.sv
// Slot allocator: lowest free slot first, else a rotating victim pointer
// confined to the non-pinned slots. Assumes free_vec never marks pinned slots.
module tlbr_alloc #(
    parameter  int ENTRIES = 16,
    parameter  int PINNED  = 4,
    localparam int SLOT_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] free_vec,
    input  logic               take,
    input  logic               rewind,
    output logic [SLOT_W-1:0]  idx
);
    logic [SLOT_W-1:0] victim;
    logic              any_free;

    // choose the lowest free slot, falling back to the victim pointer
    always_comb begin
        any_free = 1'b0;
        idx      = victim;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                idx      = SLOT_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // advance the victim pointer only when it was consumed; wrap to PINNED
    always_ff @(posedge clk) begin
        if (!rst_n || rewind)
            victim <= SLOT_W'(PINNED);
        else if (take && !any_free)
            victim <= (int'(victim) == ENTRIES - 1) ? SLOT_W'(PINNED) : victim + 1'b1;
    end

    a_r5_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(victim) >= PINNED) && (int'(victim) < ENTRIES));

    a_r5_pick_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (int'(idx) >= PINNED));

    a_r5_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (free_vec != '0)) |-> free_vec[idx]);
endmodule

// File: rtl/tlb_range.sv
// Range-matching translation buffer with pinned low slots.
// Each entry maps an aligned range of PAGE_BITS-page times 4^code onto a
// physical base. Lookups are registered (one cycle). Assumes one command and
// one lookup per cycle; a lookup sees the table before that cycle's command.
module tlb_range #(
    parameter  int VA_W      = 32,
    parameter  int PA_W      = 32,
    parameter  int PAGE_BITS = 12,
    parameter  int ENTRIES   = 16,
    parameter  int PINNED    = 4,
    parameter  int ID_W      = 16,
    localparam int SLOT_W    = $clog2(ENTRIES),
    localparam int PROT_W    = ID_W + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [PROT_W-1:0] lk_prot,
    input  logic [2:0]        cmd,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [3:0]        cmd_code,
    input  logic [PA_W-1:0]   cmd_pa,
    input  logic [PROT_W-1:0] cmd_prot,
    input  logic [SLOT_W-1:0] cmd_slot,
    output logic              cmd_err
);
    import tlbr_pkg::*;

    localparam int DIRTY_BIT = ID_W + 8;
    localparam int TRAP_BIT  = ID_W + 9;
    localparam logic [ENTRIES-1:0] UNPIN = ~((ENTRIES)'((1 << PINNED) - 1));

    // low-bit mask of a range of size page << (2*code)
    function automatic logic [VA_W-1:0] span_mask(input logic [CODE_W-1:0] c);
        logic [VA_W-1:0] m;
        for (int b = 0; b < VA_W; b++) m[b] = (b < PAGE_BITS + 2 * int'(c));
        return m;
    endfunction

    op_e op;
    assign op = op_e'(cmd);

    logic [ENTRIES-1:0] ent_vld;
    logic [VA_W-1:0]    ent_start [ENTRIES];
    logic [VA_W-1:0]    ent_mask  [ENTRIES];
    logic [PA_W-1:0]    ent_pbase [ENTRIES];
    logic [PROT_W-1:0]  ent_prot  [ENTRIES];
    logic               pend_vld;
    logic [SLOT_W-1:0]  pend_idx;

    logic [ENTRIES-1:0] hit_vec, ovl_vec, kill_vec, free_vec, vld_next;
    logic [VA_W-1:0]    q_lo, q_hi, new_mask;
    logic [VA_W:0]      p_end;
    logic [SLOT_W-1:0]  alloc_idx, wr_idx;
    logic               take, wr_addr, wr_prot, slot_bad, err_next, pend_next_vld;
    logic [SLOT_W-1:0]  pend_next_idx;
    logic [PROT_W-1:0]  prot_val;
    logic [PA_W-1:0]    sel_pa;
    logic [PROT_W-1:0]  sel_prot;

    // per-entry comparators
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlbr_match #(.VA_W(VA_W)) u_match (
            .vld(ent_vld[g]), .start(ent_start[g]), .mask(ent_mask[g]),
            .lk_va(lk_va), .q_lo(q_lo), .q_hi(q_hi),
            .hit(hit_vec[g]), .ovl(ovl_vec[g]));
    end

    // command range used for overlap purges
    always_comb begin
        new_mask = span_mask((op == OP_ASTEP) ? '0 : cmd_code);
        q_lo     = cmd_va & ~new_mask;
        q_hi     = q_lo | new_mask;
        p_end    = '0;
        if (op == OP_PURGE) begin
            q_lo  = cmd_va & ~span_mask('0);
            p_end = {1'b0, q_lo} + {1'b0, span_mask(cmd_va[CODE_W-1:0])};
            q_hi  = p_end[VA_W] ? '1 : p_end[VA_W-1:0];
        end
    end

    assign kill_vec = ovl_vec & UNPIN &
                      {ENTRIES{op == OP_INSERT || op == OP_ASTEP || op == OP_PURGE}};
    assign free_vec = UNPIN & ~(ent_vld & ~kill_vec) &
                      ~(pend_vld ? (ENTRIES)'(1) << pend_idx : '0);
    assign take     = (op == OP_INSERT) || (op == OP_ASTEP && !pend_vld);
    assign slot_bad = int'(cmd_slot) >= PINNED;

    tlbr_alloc #(.ENTRIES(ENTRIES), .PINNED(PINNED)) u_alloc (
        .clk(clk), .rst_n(rst_n), .free_vec(free_vec), .take(take),
        .rewind(op == OP_PALL), .idx(alloc_idx));

    // decode the command into table writes and next control state
    always_comb begin
        vld_next      = ent_vld & ~kill_vec;
        wr_idx        = alloc_idx;
        wr_addr       = 1'b0;
        wr_prot       = 1'b0;
        prot_val      = cmd_prot;
        err_next      = 1'b0;
        pend_next_vld = pend_vld;
        pend_next_idx = pend_idx;
        case (op)
            OP_INSERT: begin
                wr_addr = 1'b1;
                wr_prot = 1'b1;
                vld_next[wr_idx] = 1'b1;
                if (pend_vld && alloc_idx == pend_idx) pend_next_vld = 1'b0;
            end
            OP_ASTEP: begin
                wr_idx  = pend_vld ? pend_idx : alloc_idx;
                wr_addr = 1'b1;
                vld_next[wr_idx] = 1'b0;
                pend_next_vld = 1'b1;
                pend_next_idx = wr_idx;
            end
            OP_PSTEP: begin
                wr_idx        = pend_idx;
                pend_next_vld = 1'b0;
                if (pend_vld && ((cmd_va & ~ent_mask[pend_idx]) == ent_start[pend_idx])) begin
                    wr_prot = 1'b1;
                    vld_next[wr_idx] = 1'b1;
                end
            end
            OP_PALL: begin
                vld_next      = ent_vld & ~UNPIN;
                pend_next_vld = 1'b0;
            end
            OP_BINSERT: begin
                wr_idx   = cmd_slot;
                err_next = slot_bad;
                prot_val[DIRTY_BIT] = 1'b1;
                prot_val[TRAP_BIT]  = 1'b0;
                if (!slot_bad) begin
                    wr_addr = 1'b1;
                    wr_prot = 1'b1;
                    vld_next[wr_idx] = 1'b1;
                end
            end
            OP_BPURGE: begin
                err_next = slot_bad;
                if (!slot_bad) vld_next[cmd_slot] = 1'b0;
            end
            default: ;
        endcase
    end

    // lowest-index matching entry supplies the translation
    always_comb begin
        sel_pa   = '0;
        sel_prot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_pa   = ent_pbase[i] + PA_W'(lk_va - ent_start[i]);
                sel_prot = ent_prot[i];
            end
        end
    end

    // control state and registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            pend_vld <= 1'b0;
            pend_idx <= '0;
            cmd_err  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_pa    <= '0;
            lk_prot  <= '0;
        end else begin
            ent_vld  <= vld_next;
            pend_vld <= pend_next_vld;
            pend_idx <= pend_next_idx;
            cmd_err  <= err_next;
            lk_hit   <= lk_req && (hit_vec != '0);
            lk_pa    <= sel_pa;
            lk_prot  <= sel_prot;
        end
    end

    // entry payload storage (no reset; guarded by valid bits)
    always_ff @(posedge clk) begin
        if (wr_addr) begin
            ent_start[wr_idx] <= q_lo;
            ent_mask[wr_idx]  <= new_mask;
            ent_pbase[wr_idx] <= cmd_pa;
        end
        if (wr_prot) ent_prot[wr_idx] <= prot_val;
    end

    a_r1_hit_follows_match: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_hit == $past(hit_vec != '0)));

    a_r10_pinned_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT || op == OP_ASTEP || op == OP_PURGE || op == OP_PALL)
        |=> (ent_vld[PINNED-1:0] == $past(ent_vld[PINNED-1:0])));

    a_r8_purge_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PALL) |=> (((ent_vld & UNPIN) == '0) && !pend_vld));

    a_r9_bad_slot_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_BINSERT || op == OP_BPURGE) && slot_bad) |=> cmd_err);

    a_r9_bad_slot_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_BINSERT || op == OP_BPURGE) && slot_bad) |=> $stable(ent_vld));

    a_r7_pending_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> (int'(pend_idx) >= PINNED) && !ent_vld[pend_idx]);
endmodule

// File: tb/tlb_range_tb.sv
`timescale 1ns/1ps
module tlb_range_tb;
    localparam int SLOT_W = 4;
    localparam int PROT_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [31:0]       lk_va = '0;
    logic              lk_hit;
    logic [31:0]       lk_pa;
    logic [PROT_W-1:0] lk_prot;
    logic [2:0]        cmd = 3'd0;
    logic [31:0]       cmd_va = '0;
    logic [3:0]        cmd_code = '0;
    logic [31:0]       cmd_pa = '0;
    logic [PROT_W-1:0] cmd_prot = '0;
    logic [SLOT_W-1:0] cmd_slot = '0;
    logic              cmd_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_range u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [31:0] va, input logic [3:0] code,
                          input logic [31:0] pa, input logic [PROT_W-1:0] pr,
                          input logic [SLOT_W-1:0] slot);
        cmd = op; cmd_va = va; cmd_code = code; cmd_pa = pa; cmd_prot = pr; cmd_slot = slot;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic look(input logic [31:0] va);
        lk_req = 1'b1; lk_va = va;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic exp_hit(input string tag, input logic [31:0] va, input logic [31:0] pa);
        look(va);
        chk({tag, " hit"}, lk_hit, 1);
        chk({tag, " pa"}, lk_pa, pa);
    endtask

    task automatic exp_miss(input string tag, input logic [31:0] va);
        look(va);
        chk({tag, " miss"}, lk_hit, 0);
    endtask

    task automatic t_reset;
        chk("R11 cmd_err after reset", cmd_err, 0);
        exp_miss("R11 empty table", 32'h0000_0000);
    endtask

    task automatic t_basic;
        do_cmd(3'd1, 32'h0001_2345, 4'd0, 32'h8000_0000, 26'h0A51234, '0);
        exp_hit("R1 page translate", 32'h0001_2abc, 32'h8000_0abc);
        chk("R1 prot returned", lk_prot, 26'h0A51234);
        exp_miss("R2 next page outside", 32'h0001_3000);
        do_cmd(3'd1, 32'h0045_6789, 4'd2, 32'h1230_0000, 26'h0000001, '0);
        exp_hit("R2 code2 aligned range", 32'h0045_f00c, 32'h1230_f00c);
        exp_hit("R2 code2 range start", 32'h0045_0000, 32'h1230_0000);
    endtask

    task automatic t_overlap;
        do_cmd(3'd1, 32'h0046_0000, 4'd0, 32'h6000_0000, 26'h0000002, '0);
        do_cmd(3'd1, 32'h0045_2000, 4'd0, 32'h7000_0000, 26'h0000003, '0);
        exp_miss("R4 overlapped entry removed", 32'h0045_f00c);
        exp_hit("R4 new entry", 32'h0045_2010, 32'h7000_0010);
        exp_hit("R4 neighbour kept", 32'h0046_0004, 32'h6000_0004);
    endtask

    task automatic t_purge;
        do_cmd(3'd4, 32'h0001_2000, 4'd0, '0, '0, '0);
        exp_miss("R6 single page purge", 32'h0001_2abc);
        do_cmd(3'd4, 32'h0045_0001, 4'd0, '0, '0, '0);
        exp_miss("R6 code1 purge covers 16K", 32'h0045_2010);
        exp_hit("R6 outside purge range kept", 32'h0046_0004, 32'h6000_0004);
    endtask

    task automatic t_pinned;
        do_cmd(3'd6, 32'h0010_0000, 4'd0, 32'h0020_0000, 26'h20000AB, 4'd1);
        chk("R9 good slot no error", cmd_err, 0);
        exp_hit("R9 block entry", 32'h0010_0044, 32'h0020_0044);
        chk("R9 dirty set trap clear", lk_prot, 26'h10000AB);
        do_cmd(3'd5, '0, 4'd0, '0, '0, '0);
        exp_hit("R10 block kept by purge-all", 32'h0010_0044, 32'h0020_0044);
        exp_miss("R8 normal entry cleared", 32'h0046_0004);
        do_cmd(3'd4, 32'h0010_0000, 4'd0, '0, '0, '0);
        exp_hit("R10 block kept by purge", 32'h0010_0044, 32'h0020_0044);
        do_cmd(3'd1, 32'h0010_0000, 4'd1, 32'h0900_0000, 26'h0000004, '0);
        exp_hit("R3 lowest index wins", 32'h0010_0044, 32'h0020_0044);
        exp_hit("R10 insert next to block", 32'h0010_1010, 32'h0900_1010);
        do_cmd(3'd6, 32'h0030_0000, 4'd0, 32'h0, 26'h0, 4'd4);
        chk("R9 insert slot 4 rejected", cmd_err, 1);
        exp_miss("R9 rejected insert no entry", 32'h0030_0000);
        do_cmd(3'd7, '0, 4'd0, '0, '0, 4'd9);
        chk("R9 purge slot 9 rejected", cmd_err, 1);
        exp_hit("R9 rejected purge keeps block", 32'h0010_0044, 32'h0020_0044);
        do_cmd(3'd7, '0, 4'd0, '0, '0, 4'd1);
        chk("R9 block purge ok", cmd_err, 0);
        exp_hit("R9 block purged, normal seen", 32'h0010_0044, 32'h0900_0044);
    endtask

    task automatic t_two_step;
        do_cmd(3'd5, '0, 4'd0, '0, '0, '0);
        do_cmd(3'd2, 32'h0300_0123, 4'd0, 32'h0abc_d000, '0, '0);
        exp_miss("R7 pending not valid", 32'h0300_0010);
        do_cmd(3'd3, 32'h0300_0fff, 4'd0, '0, 26'h0C0BEEF, '0);
        exp_hit("R7 completed entry", 32'h0300_0010, 32'h0abc_d010);
        chk("R7 prot from step", lk_prot, 26'h0C0BEEF);
        do_cmd(3'd2, 32'h0400_0000, 4'd0, 32'h0def_0000, '0, '0);
        do_cmd(3'd3, 32'h0500_0000, 4'd0, '0, 26'h1, '0);
        exp_miss("R7 mismatched step dropped", 32'h0400_0000);
        do_cmd(3'd3, 32'h0400_0000, 4'd0, '0, 26'h1, '0);
        exp_miss("R7 pending cancelled", 32'h0400_0000);
        do_cmd(3'd5, '0, 4'd0, '0, '0, '0);
        exp_miss("R8 purge-all clears completed", 32'h0300_0010);
    endtask

    task automatic t_replace;
        do_cmd(3'd5, '0, 4'd0, '0, '0, '0);
        for (int i = 0; i < 12; i++)
            do_cmd(3'd1, 32'h1000_0000 + i * 32'h1000, 4'd0, 32'h2000_0000 + i * 32'h1000, '0, '0);
        exp_hit("R5 table full all kept", 32'h1000_b000, 32'h2000_b000);
        do_cmd(3'd1, 32'h1010_0000, 4'd0, 32'h3000_0000, '0, '0);
        exp_miss("R5 first victim is slot PINNED", 32'h1000_0000);
        exp_hit("R5 second entry survives", 32'h1000_1000, 32'h2000_1000);
        for (int k = 1; k < 13; k++)
            do_cmd(3'd1, 32'h1010_0000 + k * 32'h1000, 4'd0, 32'h3000_0000 + k * 32'h1000, '0, '0);
        exp_miss("R5 victim wrapped to PINNED", 32'h1010_0000);
        exp_hit("R5 after wrap new entry", 32'h1010_c000, 32'h3000_c000);
        exp_hit("R5 slot after wrap kept", 32'h1010_1000, 32'h3000_1000);
        do_cmd(3'd4, 32'h1010_5000, 4'd0, '0, '0, '0);
        do_cmd(3'd1, 32'h1020_0000, 4'd0, 32'h4000_0000, '0, '0);
        exp_hit("R5 free slot used first", 32'h1020_0008, 32'h4000_0008);
        exp_hit("R5 victim not consumed", 32'h1010_1000, 32'h3000_1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overlap();
        t_purge();
        t_pinned();
        t_two_step();
        t_replace();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule